// File: doc/BRIEF.md
# Inter-Processor Mailbox with Doorbells

This block lets a requester processor pass command-structure pointers to a service processor and get replies back. Each processor has its own register port with a write strobe, a byte offset, write data and read data. Three registers sit behind both ports: a request pointer, a shared flag register and a reply pointer. Both ports can read all three. Each pointer register can be written only by the side that produces it.

To make a request, the requester stores the address of a command structure in the request pointer and then sets flag bit 0, which is its doorbell. When the service side has finished, it copies the pointer into the reply pointer and writes 0x14 to the flag register, setting bits 2 and 4. Each flag bit is set by the side that owns it and cleared by the side that consumes it. Each processor has a level interrupt that stays high while the other side's doorbell bits are set. Both ports may write the flag register in the same cycle, and the register resolves that case itself.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, all three registers read zero and both interrupts are low.
- R2: A requester write to offset 0x0 stores the data in the request pointer with bits [1:0] forced to zero. The new value can be read on both ports from the cycle after the write edge.
- R3: A service write to offset 0x8 stores the data in the reply pointer with bits [1:0] forced to zero. The new value can be read on both ports from the cycle after the write edge.
- R4: A service write to offset 0x0 leaves the request pointer unchanged. A requester write to offset 0x8 leaves the reply pointer unchanged.
- R5: The flag register is at offset 0x4. A 1 written by the requester to bit 0 sets that bit. A 1 written by the service side to bit 2 or bit 4 sets that bit, so writing 0x14 sets both.
- R6: A 1 written by the service side to bit 0 clears that bit. A 1 written by the requester to bit 2 or bit 4 clears that bit. A 0 written to any of these bits leaves it unchanged.
- R7: Flag bits other than 0, 2 and 4 always read zero, whatever either side writes to them.
- R8: When both ports write offset 0x4 in the same cycle, the set and clear masks of both writes take effect together. Where a set and a clear hit the same bit, the bit ends up set.
- R9: `svc_irq` is high exactly while flag bit 0 is set. `req_irq` is high exactly while flag bit 2 or flag bit 4 is set.
- R10: Read data is a combinational function of the port's offset. Offsets other than 0x0, 0x4 and 0x8 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Requester write strobe |
| req_addr | input | 4 | Requester byte offset |
| req_wdata | input | 32 | Requester write data |
| req_rdata | output | 32 | Requester read data |
| svc_wr | input | 1 | Service write strobe |
| svc_addr | input | 4 | Service byte offset |
| svc_wdata | input | 32 | Service write data |
| svc_rdata | output | 32 | Service read data |
| svc_irq | output | 1 | Doorbell interrupt to the service side |
| req_irq | output | 1 | Reply interrupt to the requester |

## Verification
A write takes effect at the clock edge that samples it. Register contents and both interrupts show the result one edge later, because the read path and the interrupts are combinational from the registers. After every write cycle the bench therefore waits for the following falling edge. It then steps both ports' offsets across the three registers, one nanosecond apart, and compares each read and both interrupts with its own model, all before the next rising edge. Same-cycle flag writes, writes to pointers owned by the other side, bits outside the flag masks and unmapped offsets are tested directly. The bench then runs a seeded random mix of writes.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

    // Byte offsets of the mailbox registers
    localparam int OFF_REQ_PTR   = 'h0;
    localparam int OFF_FLAGS     = 'h4;
    localparam int OFF_REPLY_PTR = 'h8;

    // Write strobes decoded from one port
    typedef struct packed {
        logic req_ptr;
        logic flags;
        logic reply_ptr;
    } wr_hit_t;

    // Read selection for one port
    typedef enum logic [1:0] {
        RSEL_NONE  = 2'd0,
        RSEL_REQ   = 2'd1,
        RSEL_FLAGS = 2'd2,
        RSEL_REPLY = 2'd3
    } rsel_e;

endpackage

// File: rtl/ipc_port_decode.sv
module ipc_port_decode
    import ipc_mbx_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    output wr_hit_t           hit,
    output rsel_e             rsel
);

    always_comb begin
        hit  = '0;
        rsel = RSEL_NONE;
        if (addr == ADDR_W'(OFF_REQ_PTR)) begin
            rsel        = RSEL_REQ;
            hit.req_ptr = wr;
        end else if (addr == ADDR_W'(OFF_FLAGS)) begin
            rsel      = RSEL_FLAGS;
            hit.flags = wr;
        end else if (addr == ADDR_W'(OFF_REPLY_PTR)) begin
            rsel          = RSEL_REPLY;
            hit.reply_ptr = wr;
        end
    end

endmodule

// File: rtl/ipc_ptr_reg.sv
module ipc_ptr_reg #(
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ptr
);

    localparam logic [DATA_W-1:0] ALIGN_MASK = ~((DATA_W'(1) << ALIGN_BITS) - DATA_W'(1));

    typedef struct packed {
        logic [DATA_W-1:0] ptr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.ptr = wdata & ALIGN_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;

    // R2 / R3: a write is captured with the alignment bits cleared
    a_r2_ptr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ptr == ($past(wdata) & ALIGN_MASK)));

    // R4: without a write from the owning port the pointer holds
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(ptr));

endmodule

// File: rtl/ipc_flag_reg.sv
module ipc_flag_reg #(
    parameter int                FLAG_W   = 8,
    parameter logic [FLAG_W-1:0] REQ_MASK = 'h01,
    parameter logic [FLAG_W-1:0] SVC_MASK = 'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_we,
    input  logic [FLAG_W-1:0] req_wdata,
    input  logic              svc_we,
    input  logic [FLAG_W-1:0] svc_wdata,
    output logic [FLAG_W-1:0] flags
);

    localparam logic [FLAG_W-1:0] LIVE_MASK = REQ_MASK | SVC_MASK;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
    } state_t;

    state_t            st_d, st_q;
    logic [FLAG_W-1:0] set_m, clr_m;

    always_comb begin
        set_m = '0;
        clr_m = '0;
        if (req_we) begin
            set_m = set_m | (req_wdata & REQ_MASK);
            clr_m = clr_m | (req_wdata & SVC_MASK);
        end
        if (svc_we) begin
            set_m = set_m | (svc_wdata & SVC_MASK);
            clr_m = clr_m | (svc_wdata & REQ_MASK);
        end
        st_d       = st_q;
        st_d.flags = ((st_q.flags & ~clr_m) | set_m) & LIVE_MASK;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

    // R5 / R8: a requested set always lands, even against a clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (req_we && (req_wdata & REQ_MASK) != '0) |=>
            ((flags & $past(req_wdata) & REQ_MASK) == ($past(req_wdata) & REQ_MASK)));

    a_r5_svc_set: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_we && (svc_wdata & SVC_MASK) != '0) |=>
            ((flags & $past(svc_wdata) & SVC_MASK) == ($past(svc_wdata) & SVC_MASK)));

    // R6: a clear from the service side with no requester set drops bit 0 mask
    a_r6_svc_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_we && !req_we && (svc_wdata & REQ_MASK) != '0) |=>
            ((flags & $past(svc_wdata) & REQ_MASK) == '0));

    // R7: bits outside both masks never become set
    a_r7_dead_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (flags & ~LIVE_MASK) == '0);

    // no write from either port keeps the flags
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_we && !svc_we) |=> $stable(flags));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbx_pkg::*;
#(
    parameter int                ADDR_W     = 4,
    parameter int                DATA_W     = 32,
    parameter int                FLAG_W     = 8,
    parameter int                ALIGN_BITS = 2,
    parameter logic [FLAG_W-1:0] REQ_MASK   = 'h01,
    parameter logic [FLAG_W-1:0] SVC_MASK   = 'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] req_rdata,
    input  logic              svc_wr,
    input  logic [ADDR_W-1:0] svc_addr,
    input  logic [DATA_W-1:0] svc_wdata,
    output logic [DATA_W-1:0] svc_rdata,
    output logic              svc_irq,
    output logic              req_irq
);

    localparam int NPORT  = 2;
    localparam int P_REQ  = 0;
    localparam int P_SVC  = 1;

    logic [NPORT-1:0]             port_wr;
    logic [NPORT-1:0][ADDR_W-1:0] port_addr;
    logic [NPORT-1:0][DATA_W-1:0] port_wdata;
    logic [NPORT-1:0][DATA_W-1:0] port_rdata;
    wr_hit_t                      hit  [NPORT];
    rsel_e                        rsel [NPORT];

    logic [DATA_W-1:0] req_ptr, reply_ptr;
    logic [FLAG_W-1:0] flags;

    assign port_wr    = {svc_wr, req_wr};
    assign port_addr  = {svc_addr, req_addr};
    assign port_wdata = {svc_wdata, req_wdata};

    // One decoder and read mux per port
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        ipc_port_decode #(.ADDR_W(ADDR_W)) u_dec (
            .wr   (port_wr[p]),
            .addr (port_addr[p]),
            .hit  (hit[p]),
            .rsel (rsel[p])
        );

        always_comb begin
            unique case (rsel[p])
                RSEL_REQ:   port_rdata[p] = req_ptr;
                RSEL_FLAGS: port_rdata[p] = DATA_W'(flags);
                RSEL_REPLY: port_rdata[p] = reply_ptr;
                default:    port_rdata[p] = '0;
            endcase
        end
    end

    assign req_rdata = port_rdata[P_REQ];
    assign svc_rdata = port_rdata[P_SVC];

    // Request pointer: written by the requester only
    ipc_ptr_reg #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_req_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hit[P_REQ].req_ptr),
        .wdata (req_wdata),
        .ptr   (req_ptr)
    );

    // Reply pointer: written by the service side only
    ipc_ptr_reg #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_reply_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hit[P_SVC].reply_ptr),
        .wdata (svc_wdata),
        .ptr   (reply_ptr)
    );

    ipc_flag_reg #(.FLAG_W(FLAG_W), .REQ_MASK(REQ_MASK), .SVC_MASK(SVC_MASK)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_we    (hit[P_REQ].flags),
        .req_wdata (req_wdata[FLAG_W-1:0]),
        .svc_we    (hit[P_SVC].flags),
        .svc_wdata (svc_wdata[FLAG_W-1:0]),
        .flags     (flags)
    );

    assign svc_irq = |(flags & REQ_MASK);
    assign req_irq = |(flags & SVC_MASK);

    // R4: a service write at the request pointer offset alone changes nothing
    a_r4_svc_no_req_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_wr && svc_addr == ADDR_W'(OFF_REQ_PTR) && !req_wr) |=> $stable(req_rdata) || $changed(req_addr));

    // R9: the service interrupt rises only after a requester flag write
    a_r9_svc_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc_irq) |-> $past(req_wr && req_addr == ADDR_W'(OFF_FLAGS)));

    a_r9_req_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_irq) |-> $past(svc_wr && svc_addr == ADDR_W'(OFF_FLAGS)));

endmodule

// File: tb/tb_ipc_mailbox.sv
`timescale 1ns/1ps
module tb_ipc_mailbox;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_wr, svc_wr;
    logic [3:0]  req_addr, svc_addr;
    logic [31:0] req_wdata, svc_wdata;
    logic [31:0] req_rdata, svc_rdata;
    logic        svc_irq, req_irq;

    int total = 0;
    int bad   = 0;

    logic [31:0] m_req_ptr, m_reply_ptr;
    logic [7:0]  m_flags;

    always #4 clk = ~clk;

    ipc_mailbox dut (
        .clk(clk), .rst_n(rst_n),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata), .req_rdata(req_rdata),
        .svc_wr(svc_wr), .svc_addr(svc_addr), .svc_wdata(svc_wdata), .svc_rdata(svc_rdata),
        .svc_irq(svc_irq), .req_irq(req_irq)
    );

    function automatic logic [7:0] flag_next(logic [7:0] cur, bit rw, logic [3:0] ra,
                                             logic [31:0] rd, bit sw, logic [3:0] sa,
                                             logic [31:0] sd);
        logic [7:0] s = 8'h00;
        logic [7:0] c = 8'h00;
        if (rw && ra == 4'h4) begin s |= rd[7:0] & 8'h01; c |= rd[7:0] & 8'h14; end
        if (sw && sa == 4'h4) begin s |= sd[7:0] & 8'h14; c |= sd[7:0] & 8'h01; end
        return (cur & ~c) | s;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Called at a falling edge: sweeps both read ports over the registers
    task automatic check_all(string tag);
        check(tag, "svc_irq", 32'(svc_irq), 32'(m_flags[0]));
        check(tag, "req_irq", 32'(req_irq), 32'(m_flags[2] | m_flags[4]));
        req_addr = 4'h0; svc_addr = 4'h0; #1;
        check(tag, "req port @0", req_rdata, m_req_ptr);
        check(tag, "svc port @0", svc_rdata, m_req_ptr);
        req_addr = 4'h4; svc_addr = 4'h4; #1;
        check(tag, "req port @4", req_rdata, {24'h0, m_flags});
        check(tag, "svc port @4", svc_rdata, {24'h0, m_flags});
        req_addr = 4'h8; svc_addr = 4'h8; #1;
        check(tag, "req port @8", req_rdata, m_reply_ptr);
        check(tag, "svc port @8", svc_rdata, m_reply_ptr);
    endtask

    task automatic step(bit rw, logic [3:0] ra, logic [31:0] rd,
                        bit sw, logic [3:0] sa, logic [31:0] sd, string tag);
        @(negedge clk);
        req_wr = rw; req_addr = ra; req_wdata = rd;
        svc_wr = sw; svc_addr = sa; svc_wdata = sd;
        @(posedge clk);
        m_flags = flag_next(m_flags, rw, ra, rd, sw, sa, sd);
        if (rw && ra == 4'h0) m_req_ptr   = rd & 32'hFFFF_FFFC;
        if (sw && sa == 4'h8) m_reply_ptr = sd & 32'hFFFF_FFFC;
        @(negedge clk);
        req_wr = 1'b0; svc_wr = 1'b0;
        check_all(tag);
    endtask

    function automatic logic [3:0] pick_addr(int unsigned r);
        case (r % 5)
            0: return 4'h0;
            1: return 4'h4;
            2: return 4'h8;
            3: return 4'h4;
            default: return 4'($urandom);
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0;
        req_wr = 0; svc_wr = 0; req_addr = 0; svc_addr = 0; req_wdata = 0; svc_wdata = 0;
        m_req_ptr = 0; m_reply_ptr = 0; m_flags = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check_all("R1");

        step(1, 4'h0, 32'h1234_5677, 0, 4'h0, 0, "R2");
        step(0, 4'h0, 0, 1, 4'h8, 32'hDEAD_BEEF, "R3");
        step(1, 4'h8, 32'h5555_5555, 1, 4'h0, 32'hFFFF_FFFF, "R4");
        step(1, 4'h4, 32'h0000_0001, 0, 4'h0, 0, "R5");
        check("R9", "svc_irq after doorbell", 32'(svc_irq), 32'h1);
        step(0, 4'h0, 0, 1, 4'h4, 32'h0000_0014, "R5");
        step(0, 4'h0, 0, 1, 4'h4, 32'h0000_0001, "R6");
        step(1, 4'h4, 32'h0000_00EA, 0, 4'h0, 0, "R7");
        step(0, 4'h0, 0, 1, 4'h4, 32'h0000_00EA, "R7");
        step(1, 4'h4, 32'h0000_0004, 0, 4'h0, 0, "R6");
        check("R6", "flags after w1c bit2", {24'h0, m_flags}, 32'h10);
        step(1, 4'h4, 32'h0000_0011, 1, 4'h4, 32'h0000_0010, "R8");
        step(1, 4'h4, 32'h0000_0001, 1, 4'h4, 32'h0000_0001, "R8");
        check("R8", "set beats clear", {24'h0, m_flags}, 32'h11);
        step(1, 4'hC, 32'hFFFF_FFFF, 1, 4'hC, 32'hFFFF_FFFF, "R10");
        @(negedge clk);
        req_addr = 4'hC; svc_addr = 4'h5; #1;
        check("R10", "req unmapped read", req_rdata, 32'h0);
        check("R10", "svc unmapped read", svc_rdata, 32'h0);

        for (int i = 0; i < 400; i++) begin
            step(bit'($urandom % 2), pick_addr($urandom), $urandom,
                 bit'($urandom % 2), pick_addr($urandom), $urandom, "R9");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule